// File: doc/BRIEF.md
# Delayed-Sample Timing-Error Capture Register

This block registers a wide arithmetic result, such as the double-width product of an m-by-m multiplier, and checks that each bit settled before the capture edge. Every bit is sampled twice. The main register samples on the normal clock. A shadow register samples the same data on a second clock that runs a fixed fraction of a period later. If the two samples of a bit disagree, the data was still moving at the main edge, which means the main edge caught a stale value.

The comparison happens at the next main edge. On a mismatch the block does three things. It reloads the whole word from the shadow copy, so the output is repaired. It records which bits disagreed. It raises a single aggregate error flag for one cycle, which the surrounding system uses to re-issue the operation and to tell its latency controller that an error occurred.

The repair costs one cycle. The input word present at the repairing edge is discarded. Comparison is then suspended for one edge, because the shadow has sampled a different operation than the one the main register holds.

A two-state controller sequences this. In state ST_CAPTURE, the main register loads the input and the comparison is armed. A mismatch causes transition T_DETECT to ST_RECOVER; otherwise T_STAY keeps ST_CAPTURE. In state ST_RECOVER, the main register loads the input with comparison disarmed, and transition T_RESUME returns unconditionally to ST_CAPTURE. Reset forces ST_CAPTURE.

Top module: `razor_capture_bank`

## Requirements
- R1: While `rst_n` is low, `q_out`, `bit_err` and `err_pulse` are 0, the shadow copy is 0, and the controller is in ST_CAPTURE.
- R2: When `d_in` holds one value across both a main edge and the following delayed edge, `q_out` shows that value after the main edge, and the comparison at the next main edge reports no error.
- R3: If `d_in` changes between a main edge and the following delayed edge, then at the next main edge `bit_err[i]` becomes 1 exactly for each bit i where the main sample and the delayed sample differ.
- R4: At that same edge, `q_out` takes the delayed sample, which is the corrected word, instead of `d_in`.
- R5: `err_pulse` is the OR of the `bit_err` bits. It is 1 for exactly one main cycle per detected event.
- R6: The main edge after a repair is a recovery edge. At the repairing edge, `d_in` is discarded. At the recovery edge, `d_in` is captured into `q_out`, no error is reported, and capture with checking resumes on the following edge.
- R7: The bank is 2*OPW bits wide, one bit per product bit, and detection covers every bit position, including bit 0 and the most significant bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main | input | 1 | Normal capture clock |
| clk_late | input | 1 | Delayed copy of the capture clock; rises after `clk_main` and before the next `clk_main` rise |
| rst_n | input | 1 | Asynchronous active-low reset |
| d_in | input | 2*OPW | Result word from the datapath |
| q_out | output | 2*OPW | Registered (and repaired) result |
| bit_err | output | 2*OPW | Per-bit mismatch flags, registered |
| err_pulse | output | 1 | Aggregate error, one cycle per event |

## Verification
A word that is stable across both edges appears on `q_out` one main edge after it is presented. A disturbance injected between a main edge and its delayed edge shows up one main edge later, on `q_out`, `bit_err` and `err_pulse` together. The following edge is the recovery edge, where the word then present is captured and the error outputs return to 0. The bench changes `d_in` only at fixed offsets that avoid both clock edges. It samples directed checks 5 ns after a main edge, before the delayed edge, and compares a behavioural model against the outputs at every falling edge of `clk_main`.

// File: rtl/razor_pkg.sv
package razor_pkg;

    typedef enum logic {
        ST_CAPTURE = 1'b0,
        ST_RECOVER = 1'b1
    } rz_state_t;

endpackage

// File: rtl/razor_shadow_bank.sv
module razor_shadow_bank #(
    parameter int W = 16
) (
    input  logic         clk_late,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] shadow_q
);

    // late sample of the same data the main bank sees
    always_ff @(posedge clk_late or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else begin
            shadow_q <= d_in;
        end
    end

endmodule

// File: rtl/razor_compare.sv
module razor_compare #(
    parameter int W = 16
) (
    input  logic [W-1:0] main_q,
    input  logic [W-1:0] shadow_q,
    output logic [W-1:0] mism,
    output logic         any_mism
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign mism[i] = main_q[i] ^ shadow_q[i];
    end

    assign any_mism = |mism;

endmodule

// File: rtl/razor_ctrl.sv
module razor_ctrl
    import razor_pkg::*;
(
    input  logic clk_main,
    input  logic rst_n,
    input  logic any_mism,
    output logic cmp_en,
    output logic load_shadow
);

    rz_state_t state_q, state_d;

    always_ff @(posedge clk_main or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CAPTURE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CAPTURE: state_d = any_mism ? ST_RECOVER : ST_CAPTURE; // T_DETECT / T_STAY
            ST_RECOVER: state_d = ST_CAPTURE;                         // T_RESUME
            default:    state_d = ST_CAPTURE;
        endcase
    end

    always_comb begin
        cmp_en      = 1'b0;
        load_shadow = 1'b0;
        unique case (state_q)
            ST_CAPTURE: begin
                cmp_en      = 1'b1;
                load_shadow = any_mism;
            end
            ST_RECOVER: begin
                cmp_en      = 1'b0;
                load_shadow = 1'b0;
            end
            default: begin
                cmp_en      = 1'b0;
                load_shadow = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/razor_capture_bank.sv
module razor_capture_bank #(
    parameter int OPW = 8,
    localparam int W  = 2 * OPW
) (
    input  logic         clk_main,
    input  logic         clk_late,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out,
    output logic [W-1:0] bit_err,
    output logic         err_pulse
);

    logic [W-1:0] shadow_q;
    logic [W-1:0] mism;
    logic         any_mism;
    logic         cmp_en;
    logic         load_shadow;
    logic [W-1:0] main_d;

    razor_shadow_bank #(.W(W)) u_shadow (
        .clk_late (clk_late),
        .rst_n    (rst_n),
        .d_in     (d_in),
        .shadow_q (shadow_q)
    );

    razor_compare #(.W(W)) u_cmp (
        .main_q   (q_out),
        .shadow_q (shadow_q),
        .mism     (mism),
        .any_mism (any_mism)
    );

    razor_ctrl u_ctrl (
        .clk_main    (clk_main),
        .rst_n       (rst_n),
        .any_mism    (any_mism),
        .cmp_en      (cmp_en),
        .load_shadow (load_shadow)
    );

    // per-bit restore mux in front of the main flip-flops
    for (genvar i = 0; i < W; i++) begin : g_mux
        assign main_d[i] = load_shadow ? shadow_q[i] : d_in[i];
    end

    always_ff @(posedge clk_main or negedge rst_n) begin
        if (!rst_n) begin
            q_out     <= '0;
            bit_err   <= '0;
            err_pulse <= 1'b0;
        end else begin
            q_out     <= main_d;
            bit_err   <= cmp_en ? mism : '0;
            err_pulse <= cmp_en & any_mism;
        end
    end

endmodule

// File: rtl/razor_capture_chk.sv
module razor_capture_chk #(
    parameter int W = 16
) (
    input logic         clk_main,
    input logic         rst_n,
    input logic [W-1:0] q_out,
    input logic [W-1:0] bit_err,
    input logic         err_pulse
);

    // R1
    reset_clear_chk: assert property (@(posedge clk_main)
        !rst_n |-> (q_out == '0 && bit_err == '0 && !err_pulse));

    // R5
    pulse_single_chk: assert property (@(posedge clk_main) disable iff (!rst_n)
        err_pulse |=> !err_pulse);

    // R5
    pulse_or_chk: assert property (@(posedge clk_main) disable iff (!rst_n)
        err_pulse == (|bit_err));

    // R4
    repair_diff_chk: assert property (@(posedge clk_main) disable iff (!rst_n)
        err_pulse |-> ((q_out ^ $past(q_out)) == bit_err));

endmodule

bind razor_capture_bank razor_capture_chk #(.W(W)) i_chk (
    .clk_main  (clk_main),
    .rst_n     (rst_n),
    .q_out     (q_out),
    .bit_err   (bit_err),
    .err_pulse (err_pulse)
);

// File: tb/test_razor_capture_bank.sv
module test_razor_capture_bank;

    localparam int OPW = 8;
    localparam int W   = 2 * OPW;

    logic         clk_main = 1'b0;
    logic         clk_late = 1'b0;
    logic         rst_n    = 1'b1;
    logic [W-1:0] d_in     = '0;
    logic [W-1:0] q_out;
    logic [W-1:0] bit_err;
    logic         err_pulse;

    int n_chk  = 0;
    int n_fail = 0;
    bit run_cmp = 1'b0;
    bit done    = 1'b0;

    razor_capture_bank #(.OPW(OPW)) i_razor_capture_bank (
        .clk_main  (clk_main),
        .clk_late  (clk_late),
        .rst_n     (rst_n),
        .d_in      (d_in),
        .q_out     (q_out),
        .bit_err   (bit_err),
        .err_pulse (err_pulse)
    );

    // 50 MHz main clock, delayed copy 6 ns later
    always #10 clk_main = ~clk_main;
    initial begin
        #6;
        forever #10 clk_late = ~clk_late;
    end

    task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference
    logic [W-1:0] m_main = '0, m_late = '0, e_err = '0;
    bit           e_pulse = 1'b0, m_rec = 1'b0;

    always @(posedge clk_late) m_late = rst_n ? d_in : '0;

    always @(posedge clk_main) begin
        if (!rst_n) begin
            m_main = '0; e_err = '0; e_pulse = 1'b0; m_rec = 1'b0;
        end else if (!m_rec && (m_main != m_late)) begin
            e_err = m_main ^ m_late; e_pulse = 1'b1; m_main = m_late; m_rec = 1'b1;
        end else begin
            e_err = '0; e_pulse = 1'b0; m_main = d_in; m_rec = 1'b0;
        end
    end

    always @(negedge clk_main) begin
        if (run_cmp && rst_n) begin
            check(q_out == m_main, "R2 R4 model q_out", q_out, m_main);
            check(bit_err == e_err, "R3 model bit_err", bit_err, e_err);
            check(err_pulse == e_pulse, "R5 model err_pulse", W'(err_pulse), W'(e_pulse));
        end
    end

    task automatic put(input logic [W-1:0] v);
        @(posedge clk_main);
        #12 d_in = v;
    endtask

    // a is caught by the main edge, b by the delayed edge, c discarded, nxt captured
    task automatic inject(input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic [W-1:0] c, input logic [W-1:0] nxt);
        @(posedge clk_main);
        #12 d_in = a;
        @(posedge clk_main);
        #3  d_in = b;
        #9  d_in = c;
        @(posedge clk_main);
        #5;
        check(q_out == b, "R4 repaired q_out", q_out, b);
        check(bit_err == (a ^ b), "R3 bit_err", bit_err, a ^ b);
        check(err_pulse == 1'b1, "R5 pulse high", W'(err_pulse), W'(1));
        #7 d_in = nxt;
        @(posedge clk_main);
        #5;
        check(q_out == nxt, "R6 recovery capture", q_out, nxt);
        check(bit_err == '0, "R6 no error on recovery", bit_err, '0);
        check(err_pulse == 1'b0, "R5 pulse one cycle", W'(err_pulse), W'(0));
    endtask

    initial begin
        #1 rst_n = 1'b0;
        d_in = 16'hBEEF;
        #11;
        check(q_out == '0, "R1 reset q_out", q_out, '0);
        check(bit_err == '0, "R1 reset bit_err", bit_err, '0);
        check(err_pulse == 1'b0, "R1 reset err_pulse", W'(err_pulse), W'(0));
        #31 rst_n = 1'b1;
        run_cmp = 1'b1;
        // R2 stable words
        put(16'hA5A5); put(16'hFFFF); put(16'h0000); put(16'h1234);
        @(posedge clk_main); #5;
        check(q_out == 16'h1234, "R2 stable capture", q_out, 16'h1234);
        check(err_pulse == 1'b0, "R2 no error", W'(err_pulse), W'(0));
        inject(16'h00F0, 16'h0F0F, 16'h5555, 16'h3333);
        put(16'h3333); put(16'hC3C3);
        // R7 lsb and msb positions
        inject(16'h0000, 16'h0001, 16'h7777, 16'h2222);
        put(16'h2222);
        inject(16'h7FFF, 16'hFFFF, 16'h0101, 16'h4444);
        inject(16'hFFFF, 16'h0000, 16'hAAAA, 16'h9999);
        put(16'h9999); put(16'h6666); put(16'h6666);
        @(posedge clk_main); #5;
        check(q_out == 16'h6666, "R7 after events", q_out, 16'h6666);
        check(bit_err == '0, "R2 quiet after events", bit_err, '0);
        repeat (3) @(posedge clk_main);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk_main);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
        $finish;
    end

endmodule